// File: doc/BRIEF.md
# Waveform Timer/Counter Channel

This block is a single 16-bit timer channel, programmed through a small register port. It counts edges of a chosen time base and compares the running count against two software-written thresholds, a low one and a period one. From those compare events it keeps latched status flags, raises a maskable interrupt request, and drives a square-wave output.

The counter can run in three ways. It can run freely and wrap around. It can restart from zero on every period match to give a steady periodic event. It can halt on the period match to give a one-shot delay. Software starts, stops and restarts the counter through a command register. The time base is one of four divided copies of the system clock, a slow-clock input, or an external count input. Both inputs are assumed to be synchronous to `clk` already.

Register map (3-bit `addr`): 0 mode, 1 low threshold, 2 period threshold, 3 count value (read only), 4 command (write only), 5 interrupt enable (write sets mask bits, read returns the mask), 6 interrupt disable (write clears mask bits), 7 status (read only, reading it clears the flags). Reads return the value in `rdata` one cycle after `rd_en` is sampled.

Top module: `wave_timer_chan`

## Requirements
- R1: The mode register field bits [2:0] picks the time base. 0, 1, 2 and 3 give one count every 2, 8, 32 and 128 `clk` cycles. 4 gives one count per rising edge of `slow_in` and 5 gives one count per rising edge of `ext_in`. 6 and 7 give no counts. While running, the 16-bit count rises by one per count event.
- R2: With mode bit 3 at 0 (free mode), the count goes from 0xFFFF to 0 and a match with the period threshold never restarts it.
- R3: With mode bit 3 at 1, a count event that finds the count equal to the period threshold loads 0 instead of incrementing, so the period is threshold+1 events.
- R4: With mode bit 4 at 1, a count event that finds the count equal to the period threshold stops the counter on the next cycle. The count stays at the threshold in free mode and becomes 0 with mode bit 3 set.
- R5: A command write with bit 0 set starts counting and one with bit 1 set stops it, both from the next cycle. When both bits are set, stop wins. A stopped counter holds its value.
- R6: A command write with bit 2 set loads 0 into the count and takes precedence over a count event in the same cycle. It does not change whether the counter runs, so with the counter stopped it only zeroes the count.
- R7: Status bit 0 latches on a low-threshold match and status bit 1 latches on a period match; status bit 8 reads whether the counter runs. A status read clears bits 0 and 1. A match in the same cycle as the read remains latched.
- R8: `irq_o` is high exactly when some latched status flag has its mask bit set (mask bits [1:0] correspond to status bits [1:0]). Writing 0xFF to the disable register clears every mask bit.
- R9: With mode bit 5 set, a low-threshold match drives `wave_o` to 1. With mode bit 6 set, a period match drives it to 0. When both match in one event, 0 wins.
- R10: After reset all registers, the count, `rdata`, `wave_o` and `irq_o` are 0 and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 1 | External count input, synchronous to clk |
| slow_in | input | 1 | Slow clock input, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the collisions between events that land on the same clock edge. A status read that coincides with a new match must not lose the flag; a design that clears last would drop interrupts. Trigger and count event in one cycle must give 0, not 1. Stop and start written together must leave the counter halted. When the two thresholds are equal, the output must end low, and a design with the wrong priority would leave it high. It also checks that a one-shot halts exactly at the threshold rather than one past it, that free mode runs past the period threshold and through 0xFFFF, and that each divider yields exactly its share of counts over a fixed window whatever the prescaler phase.

// File: rtl/wtc_pkg.sv
// Package: shared register addresses, mode layout and flag positions for
// the waveform timer channel. Assumes a 3-bit register address.
package wtc_pkg;
    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_LOW  = 3'd1;
    localparam logic [2:0] A_PER  = 3'd2;
    localparam logic [2:0] A_CNT  = 3'd3;
    localparam logic [2:0] A_CMD  = 3'd4;
    localparam logic [2:0] A_IEN  = 3'd5;
    localparam logic [2:0] A_IDIS = 3'd6;
    localparam logic [2:0] A_STAT = 3'd7;

    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_TRIG  = 2;

    localparam int NFLAG    = 2;
    localparam int FLG_LOW  = 0;
    localparam int FLG_PER  = 1;
    localparam int STAT_RUN = 8;

    localparam int NSRC = 6;

    typedef struct packed {
        logic       clr_on_per;
        logic       set_on_low;
        logic       stop_on_per;
        logic       restart_on_per;
        logic [2:0] src_sel;
    } mode_t;
endpackage

// File: rtl/wtc_tick_gen.sv
// Module: time-base selector. A free-running prescaler gives four divided
// count enables (divide by 2, 8, 32, 128); two input edge detectors give
// the slow and external enables. Assumes both inputs are already
// synchronous to clk. Output is a one-cycle count enable.
module wtc_tick_gen #(
    parameter int NDIV    = 4,
    parameter int PRESC_W = 2 * NDIV - 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_sel,
    input  logic       slow_in,
    input  logic       ext_in,
    output logic       tick
);
    import wtc_pkg::*;

    logic [PRESC_W-1:0] presc;
    logic               slow_q;
    logic               ext_q;
    logic [NSRC-1:0]    src;

    // Prescaler and previous-level registers for the edge detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc  <= '0;
            slow_q <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            presc  <= presc + 1'b1;
            slow_q <= slow_in;
            ext_q  <= ext_in;
        end
    end

    // One enable per divider: low 2*i+1 prescaler bits all ones.
    for (genvar i = 0; i < NDIV; i++) begin : g_div
        localparam int LB = 2 * i + 1;
        assign src[i] = &presc[LB-1:0];
    end

    assign src[NDIV]   = slow_in & ~slow_q;
    assign src[NDIV+1] = ext_in  & ~ext_q;

    // Pick the selected enable; unused codes give no counts.
    always_comb begin
        tick = 1'b0;
        if (int'(src_sel) < NSRC) tick = src[src_sel];
    end
endmodule

// File: rtl/wtc_counter.sv
// Module: 16-bit up counter with run state, trigger, period restart and
// one-shot stop. Compare events are reported only on a count event of a
// running counter that is not overridden by a trigger.
module wtc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cmd_start,
    input  logic         cmd_stop,
    input  logic         cmd_trig,
    input  logic         restart_on_per,
    input  logic         stop_on_per,
    input  logic [W-1:0] low_thr,
    input  logic [W-1:0] per_thr,
    output logic [W-1:0] cnt,
    output logic         running,
    output logic         low_hit,
    output logic         per_hit
);
    logic step;

    // A count event only acts when running and not overridden by a trigger.
    assign step    = running & tick & ~cmd_trig;
    assign low_hit = step & (cnt == low_thr);
    assign per_hit = step & (cnt == per_thr);

    // Count register: trigger, period restart, one-shot hold, increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (cmd_trig)                  cnt <= '0;
        else if (per_hit && restart_on_per) cnt <= '0;
        else if (per_hit && stop_on_per)    cnt <= cnt;
        else if (step)                      cnt <= cnt + 1'b1;
    end

    // Run state: stop command wins, then start, then one-shot stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                      running <= 1'b0;
        else if (cmd_stop)               running <= 1'b0;
        else if (cmd_start)              running <= 1'b1;
        else if (per_hit && stop_on_per) running <= 1'b0;
    end
endmodule

// File: rtl/wave_timer_chan.sv
// Module: top of the waveform timer channel. Holds the register file,
// status flags, interrupt mask and waveform output; instantiates the
// time-base selector and the counter. Reads are registered (one cycle).
module wave_timer_chan #(
    parameter int W    = 16,
    parameter int NDIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_in,
    input  logic         slow_in,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         wave_o,
    output logic         irq_o
);
    import wtc_pkg::*;

    localparam int MODE_W = $bits(mode_t);

    mode_t            mode_q;
    logic [W-1:0]     low_q;
    logic [W-1:0]     per_q;
    logic [NFLAG-1:0] mask_q;
    logic [NFLAG-1:0] flags_q;
    logic [W-1:0]     cnt;
    logic             running;
    logic             low_hit;
    logic             per_hit;
    logic             tick;
    logic             wr_cmd;
    logic             rd_stat;

    assign wr_cmd  = wr_en && (addr == A_CMD);
    assign rd_stat = rd_en && (addr == A_STAT);

    wtc_tick_gen #(.NDIV(NDIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (mode_q.src_sel),
        .slow_in (slow_in),
        .ext_in  (ext_in),
        .tick    (tick)
    );

    wtc_counter #(.W(W)) u_cnt (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .cmd_start      (wr_cmd & wdata[CMD_START]),
        .cmd_stop       (wr_cmd & wdata[CMD_STOP]),
        .cmd_trig       (wr_cmd & wdata[CMD_TRIG]),
        .restart_on_per (mode_q.restart_on_per),
        .stop_on_per    (mode_q.stop_on_per),
        .low_thr        (low_q),
        .per_thr        (per_q),
        .cnt            (cnt),
        .running        (running),
        .low_hit        (low_hit),
        .per_hit        (per_hit)
    );

    // Writable configuration registers and interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            low_q  <= '0;
            per_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_MODE:  mode_q <= mode_t'(wdata[MODE_W-1:0]);
                A_LOW:   low_q  <= wdata;
                A_PER:   per_q  <= wdata;
                A_IEN:   mask_q <= mask_q | wdata[NFLAG-1:0];
                A_IDIS:  mask_q <= mask_q & ~wdata[NFLAG-1:0];
                default: ;
            endcase
        end
    end

    // Status flags: cleared by a status read, new matches set afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_stat ? '0 : flags_q) | {per_hit, low_hit};
    end

    // Waveform output: period-match clear takes priority over low-match set.
    always_ff @(posedge clk) begin
        if (!rst_n)                             wave_o <= 1'b0;
        else if (per_hit && mode_q.clr_on_per)  wave_o <= 1'b0;
        else if (low_hit && mode_q.set_on_low)  wave_o <= 1'b1;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            rdata <= '0;
            case (addr)
                A_MODE: rdata[MODE_W-1:0] <= mode_q;
                A_LOW:  rdata <= low_q;
                A_PER:  rdata <= per_q;
                A_CNT:  rdata <= cnt;
                A_IEN:  rdata[NFLAG-1:0] <= mask_q;
                A_STAT: begin
                    rdata[NFLAG-1:0] <= flags_q;
                    rdata[STAT_RUN]  <= running;
                end
                default: ;
            endcase
        end
    end

    assign irq_o = |(flags_q & mask_q);
endmodule

// File: rtl/wtc_checker.sv
// Module: property checker for the waveform timer channel, bound to the
// top. Observes the register port and the counter's internal state.
module wtc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   addr,
    input logic [W-1:0] wdata,
    input logic         running,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per_thr,
    input logic         restart_on_per,
    input logic         stop_on_per,
    input logic         tick,
    input logic         irq_o
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (addr == 3'd4);

    assert_trigger_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[2]) |=> (cnt == '0));

    assert_stop_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[1]) |=> !running);

    assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(cmd_wr && wdata[2])) |=> $stable(cnt));

    assert_period_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && restart_on_per && cnt == per_thr && !(cmd_wr && wdata[2]))
        |=> (cnt == '0));

    assert_one_shot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && stop_on_per && cnt == per_thr && !(cmd_wr && (wdata[2] || wdata[0])))
        |=> !running);

    assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd6 && wdata[7:0] == 8'hFF) |=> !irq_o);
endmodule

bind wave_timer_chan wtc_checker #(.W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .running        (running),
    .cnt            (cnt),
    .per_thr        (per_q),
    .restart_on_per (mode_q.restart_on_per),
    .stop_on_per    (mode_q.stop_on_per),
    .tick           (tick),
    .irq_o          (irq_o)
);

// File: tb/wave_timer_chan_test.sv
// Bench: directed corner cases plus seeded random register/pulse traffic,
// checked against a bench-side model built from the requirements.
module wave_timer_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_in = 1'b0, slow_in = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        wave_o, irq_o;

    int tests = 0, fails = 0, cycles = 0;
    bit m_chk = 1'b1;

    // model state
    logic [6:0]  m_mode = '0;
    logic [15:0] m_low = '0, m_per = '0, m_cnt = '0;
    logic [1:0]  m_mask = '0, m_flags = '0;
    logic        m_run = 0, m_wave = 0, m_pext = 0, m_pslow = 0;

    wave_timer_chan uut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {9'd0, m_mode};
            3'd1: return m_low;
            3'd2: return m_per;
            3'd3: return m_cnt;
            3'd5: return {14'd0, m_mask};
            3'd7: return {7'd0, m_run, 6'd0, m_flags};
            default: return 16'd0;
        endcase
    endfunction

    // One clock cycle of stimulus, model update and checks.
    task automatic cyc(input logic we, input logic [2:0] wa, input logic [15:0] wd,
                       input logic re, input logic [2:0] rs, input logic ex,
                       input logic sl, input string tag);
        logic [15:0] exp_rd;
        logic tk, st, rah, rch, trg, go, halt;
        wr_en = we; rd_en = re; addr = we ? wa : rs; wdata = wd;
        ext_in = ex; slow_in = sl;
        if (we && re && wa != rs) addr = wa;
        exp_rd = model_read(rs);
        @(negedge clk);
        if (m_chk && re) check({tag, " read"}, rdata, exp_rd);
        tk = (m_mode[2:0] == 3'd5) ? (ex & ~m_pext) :
             (m_mode[2:0] == 3'd4) ? (sl & ~m_pslow) : 1'b0;
        trg  = we && wa == 3'd4 && wd[2];
        go   = we && wa == 3'd4 && wd[0];
        halt = we && wa == 3'd4 && wd[1];
        st  = m_run & tk & ~trg;
        rah = st && m_cnt == m_low;
        rch = st && m_cnt == m_per;
        if (trg) m_cnt = 0;
        else if (rch && m_mode[3]) m_cnt = 0;
        else if (rch && m_mode[4]) m_cnt = m_cnt;
        else if (st) m_cnt = m_cnt + 1;
        if (halt) m_run = 0; else if (go) m_run = 1; else if (rch && m_mode[4]) m_run = 0;
        m_flags = ((re && rs == 3'd7) ? 2'b00 : m_flags) | {rch, rah};
        if (rch && m_mode[6]) m_wave = 0; else if (rah && m_mode[5]) m_wave = 1;
        if (we) case (wa)
            3'd0: m_mode = wd[6:0];
            3'd1: m_low = wd;
            3'd2: m_per = wd;
            3'd5: m_mask = m_mask | wd[1:0];
            3'd6: m_mask = m_mask & ~wd[1:0];
            default: ;
        endcase
        m_pext = ex; m_pslow = sl;
        if (m_chk) begin
            check({tag, " wave_o"}, {15'd0, wave_o}, {15'd0, m_wave});
            check({tag, " irq_o"}, {15'd0, irq_o}, {15'd0, |(m_flags & m_mask)});
        end
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        cyc(1, a, d, 0, 0, 0, 0, tag);
    endtask
    task automatic rd(input logic [2:0] a, input string tag);
        cyc(0, 0, 0, 1, a, 0, 0, tag);
    endtask
    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic pulse(input string tag);
        cyc(0, 0, 0, 0, 0, 1, 0, tag);
        idle(tag);
    endtask
    task automatic rd_raw(input logic [2:0] a, output logic [15:0] v);
        cyc(0, 0, 0, 1, a, 0, 0, "raw");
        v = rdata;
    endtask

    initial begin
        logic [15:0] va, vb, vc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 wave_o", {15'd0, wave_o}, 16'd0);
        check("R10 irq_o", {15'd0, irq_o}, 16'd0);
        rd(3'd0, "R10 mode"); rd(3'd3, "R10 count"); rd(3'd7, "R10 status");
        // R5 start/stop priority
        wr(3'd0, 16'h0005, "R5 mode");
        wr(3'd4, 16'h0003, "R5 both"); rd(3'd7, "R5 stop wins");
        wr(3'd4, 16'h0001, "R5 start"); rd(3'd7, "R5 running");
        pulse("R1 ext count"); pulse("R1 ext count"); rd(3'd3, "R1 ext count");
        wr(3'd4, 16'h0002, "R5 stop"); pulse("R5 held"); rd(3'd3, "R5 held count");
        // R6 trigger while stopped only zeroes
        wr(3'd4, 16'h0004, "R6 trig off"); rd(3'd3, "R6 zeroed"); rd(3'd7, "R6 still off");
        // R6 trigger beats a same-cycle count event
        wr(3'd4, 16'h0001, "R6 start"); pulse("R6"); pulse("R6");
        cyc(1, 3'd4, 16'h0004, 0, 0, 1, 0, "R6 trig+tick"); idle("R6");
        rd(3'd3, "R6 trig wins");
        // R3/R9/R7/R8 periodic with waveform
        wr(3'd1, 16'd2, "R3 low"); wr(3'd2, 16'd4, "R3 per");
        wr(3'd0, 16'h0068, "R3 mode"); // src 0? fix below
        wr(3'd0, 16'h006D, "R9 mode restart+set+clr ext");
        wr(3'd5, 16'h0003, "R8 enable");
        wr(3'd4, 16'h0005, "R3 start+trig");
        for (int i = 0; i < 12; i++) begin
            pulse("R9 waveform"); rd(3'd3, "R3 count");
        end
        rd(3'd7, "R7 flags");
        // R7 match during status read stays latched
        for (int i = 0; i < 3; i++) pulse("R7");
        cyc(0, 0, 0, 1, 3'd7, 1, 0, "R7 read+hit"); idle("R7");
        rd(3'd7, "R7 set wins");
        // R8 mask all
        wr(3'd6, 16'h00FF, "R8 mask all"); rd(3'd5, "R8 mask");
        // R9 equal thresholds: clear wins
        wr(3'd1, 16'd3, "R9 low=per"); wr(3'd2, 16'd3, "R9");
        wr(3'd4, 16'h0005, "R9");
        for (int i = 0; i < 10; i++) pulse("R9 equal");
        // R4 one-shot in free mode, then with restart
        wr(3'd0, 16'h0015, "R4 mode"); wr(3'd4, 16'h0005, "R4 go");
        for (int i = 0; i < 7; i++) pulse("R4 one-shot");
        rd(3'd3, "R4 held at thr"); rd(3'd7, "R4 stopped");
        wr(3'd0, 16'h001D, "R4 mode restart"); wr(3'd4, 16'h0005, "R4 go");
        for (int i = 0; i < 6; i++) pulse("R4 one-shot restart");
        rd(3'd3, "R4 zero"); rd(3'd7, "R4 stopped");
        // R1 slow input
        wr(3'd0, 16'h0004, "R1 slow"); wr(3'd4, 16'h0005, "R1 slow");
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 1, "R1 slow"); idle("R1 slow");
        end
        rd(3'd3, "R1 slow count");
        // random traffic, external source
        wr(3'd0, 16'h0005, "rand");
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r <= 6) pulse("R3 R9 random pulse");
            else case (r)
                7:  wr(3'd4, 16'($urandom % 8) & (($urandom % 4 == 0) ? 16'h7 : 16'h5), "R5 R6 random cmd");
                8:  rd(3'd3, "R2 R3 random count");
                9:  rd(3'd7, "R7 random status");
                10: wr(3'd2, 16'($urandom % 6), "R3 random per");
                11: wr(3'd1, 16'($urandom % 6), "R9 random low");
                12: wr(3'd0, {9'd0, 4'($urandom), 3'd5}, "R4 random mode");
                13: wr(3'd5, 16'($urandom % 4), "R8 random ien");
                14: wr(3'd6, 16'($urandom % 4), "R8 random idis");
                default: rd(3'd5, "R8 random mask");
            endcase
        end
        // R1 internal dividers: fixed 256-cycle window
        m_chk = 1'b0;
        for (int s = 0; s < 4; s++) begin
            wr(3'd0, 16'(s), "R1 div"); wr(3'd4, 16'h0005, "R1 div");
            rd_raw(3'd3, va);
            for (int k = 0; k < 255; k++) idle("R1");
            rd_raw(3'd3, vb);
            check("R1 divider count", vb - va, 16'(256 >> (2 * s + 1)));
        end
        // R2 free mode passes period threshold and wraps at 0xFFFF
        wr(3'd2, 16'd5, "R2"); wr(3'd0, 16'h0000, "R2"); wr(3'd4, 16'h0005, "R2");
        rd_raw(3'd3, va);
        for (int k = 0; k < 63; k++) idle("R2");
        rd_raw(3'd3, vb);
        check("R2 runs past threshold", vb - va, 16'd32);
        for (int k = 0; k < 131071; k++) idle("R2");
        rd_raw(3'd3, vc);
        check("R2 wrap", vc, vb);
        rd_raw(3'd7, va);
        check("R2 still running", {15'd0, va[8]}, 16'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule